// File: doc/BRIEF.md
# Contact image sensor timing generator

This block drives a chain of linear contact image sensor dies from a fast system clock. It divides the system clock into a pixel clock and opens each scan line with a single start pulse. It drives the control of the switch that resets the video line. It also strobes the ADC once in every pixel period, at the point where the charged video line is closest to its peak. Every edge falls on a system clock edge. The pixel period is an integer number of system clock cycles.

Software sets the divider, duty selection, line period, die count and amplifier delay on the configuration inputs. The block samples them at the first cycle of every line, so a change takes effect on the next line and no line is ever a mix of two settings. Two outputs go to the capture logic downstream. A pixel-valid pulse comes with each useful ADC strobe and carries the pixel's index in the chain. A line-valid level covers the whole scan of the chain. A line period shorter than the chain can scan is stretched to the minimum, and a sticky flag records that this happened.

Top module: `cis_line_timer`

## Requirements
- R1: After reset, and for as long as `enable` is low, every output is low, `pix_idx` is zero and `cfg_err` is low.
- R2: The pixel clock period is P = max(`cfg_div`, MIN_DIV) system clock cycles, with MIN_DIV = 4, measured between consecutive rising edges of `pix_clk`.
- R3: `pix_clk` is high for H cycles after each rising edge. H = floor(P/2) when `cfg_duty` is 2, or when `cfg_duty` is 0 or 3 and P <= FAST_DIV_MAX (20 by default). Otherwise H = floor(P/4), which always applies for `cfg_duty` = 1.
- R4: `vid_rst` equals `pix_clk` on every cycle, so the video line is shorted exactly during the high phase.
- R5: `adc_stb` pulses for one cycle per pixel period, S = min(P - H + `cfg_dly`, P - 1) cycles after the rising edge of `pix_clk`, and never while `pix_clk` is high.
- R6: `start_pulse` rises one cycle after the rising edge of `pix_clk` that opens a line and stays high for P - 2 cycles. It therefore spans exactly one falling edge of `pix_clk` and never toggles on a rising edge. It is only high while `line_valid` is high.
- R7: With N = max(`cfg_dies`, 1) x PIX_PER_DIE, `pix_valid` comes with the strobe of each of the first N pixel periods of a line, and `pix_idx` runs 0 to N-1 in ascending order. `line_valid` is high for exactly N x P cycles per line.
- R8: The rising edges of `start_pulse` are max(`cfg_line`, N) x P cycles apart. `cfg_line` is counted in pixel periods.
- R9: `cfg_err` is set when a line starts with `cfg_line` < N. Only reset clears it.
- R10: Configuration is sampled when a line starts. When `enable` drops, the current line completes with all N pixels, and then all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run lines continuously while high |
| cfg_div | input | DIV_W | Pixel period in system clock cycles |
| cfg_duty | input | 2 | Duty select: 0/3 auto by rate, 1 quarter, 2 half |
| cfg_line | input | LINE_W | Line period (integration time) in pixel periods |
| cfg_dies | input | DIE_W | Number of cascaded dies (0 treated as 1) |
| cfg_dly | input | DLY_W | Amplifier delay added to the strobe offset, in system cycles |
| pix_clk | output | 1 | Pixel clock to the sensor chain |
| vid_rst | output | 1 | Video-line reset switch control |
| start_pulse | output | 1 | Line start pulse to the first die |
| adc_stb | output | 1 | ADC sample strobe, one per pixel period |
| pix_valid | output | 1 | Strobe belongs to a real pixel of the chain |
| pix_idx | output | LINE_W | Index of the pixel being sampled |
| line_valid | output | 1 | High while the chain is being scanned |
| cfg_err | output | 1 | Sticky flag: a line period was too short and was clamped |

## Verification
On every cycle, the assertions check the following: the start pulse never toggles on a rising edge of the pixel clock, the strobe always lands in the low phase, pixel-valid stays inside line-valid and comes with a strobe, pixel indices climb by one, and the error flag stays set. Whether the numbers come out right can only be shown by the bench's scenarios, which measure them at the ports and compare them with expected values computed from the configuration. These numbers are the period, the high width picked by each duty selection, the strobe offset including its clamp, the line spacing including the short-line clamp, and the clean stop after `enable` falls.

// File: rtl/cis_timer_pkg.sv
package cis_timer_pkg;

   typedef enum logic [1:0] {
      DUTY_AUTO     = 2'd0,
      DUTY_QUARTER  = 2'd1,
      DUTY_HALF     = 2'd2,
      DUTY_AUTO_ALT = 2'd3
   } duty_sel_e;

   // Half duty when forced, or in auto mode when the pixel rate is high.
   function automatic logic pick_half(input logic [1:0] sel, input logic fast);
      logic half;
      case (sel)
         DUTY_HALF:    half = 1'b1;
         DUTY_QUARTER: half = 1'b0;
         default:      half = fast;
      endcase
      return half;
   endfunction

endpackage

// File: rtl/cis_cfg_shadow.sv
module cis_cfg_shadow
   import cis_timer_pkg::*;
#(
   parameter int DIV_W        = 8,
   parameter int DLY_W        = 8,
   parameter int LINE_W       = 16,
   parameter int DIE_W        = 5,
   parameter int PIX_PER_DIE  = 192,
   parameter int MIN_DIV      = 4,
   parameter int FAST_DIV_MAX = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DIV_W-1:0]  div_in,
   input  logic [1:0]        duty_in,
   input  logic [LINE_W-1:0] line_in,
   input  logic [DIE_W-1:0]  dies_in,
   input  logic [DLY_W-1:0]  dly_in,
   output logic [DIV_W-1:0]  per_q,
   output logic [DIV_W-1:0]  high_q,
   output logic [DIV_W-1:0]  smp_q,
   output logic [LINE_W-1:0] npix_q,
   output logic [LINE_W-1:0] span_q,
   output logic              err_q
);

   localparam int SW = DIV_W + 1;

   logic [DIV_W-1:0]  per_c, high_c, smp_c;
   logic [SW-1:0]     smp_raw;
   logic [DIE_W-1:0]  dies_c;
   logic [LINE_W-1:0] npix_c, span_c;
   logic              short_c;

   always_comb begin
      per_c   = (div_in < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_in;
      high_c  = pick_half(duty_in, per_c <= DIV_W'(FAST_DIV_MAX)) ? (per_c >> 1)
                                                                  : (per_c >> 2);
      smp_raw = {1'b0, per_c} - {1'b0, high_c} + SW'(dly_in);
      smp_c   = (smp_raw >= {1'b0, per_c}) ? (per_c - DIV_W'(1)) : smp_raw[DIV_W-1:0];
      dies_c  = (dies_in == '0) ? DIE_W'(1) : dies_in;
      npix_c  = LINE_W'(dies_c) * LINE_W'(PIX_PER_DIE);
      short_c = line_in < npix_c;
      span_c  = short_c ? npix_c : line_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= DIV_W'(MIN_DIV);
         high_q <= DIV_W'(1);
         smp_q  <= DIV_W'(MIN_DIV - 1);
         npix_q <= LINE_W'(PIX_PER_DIE);
         span_q <= LINE_W'(PIX_PER_DIE);
         err_q  <= 1'b0;
      end else if (load) begin
         per_q  <= per_c;
         high_q <= high_c;
         smp_q  <= smp_c;
         npix_q <= npix_c;
         span_q <= span_c;
         if (short_c) err_q <= 1'b1;
      end
   end

endmodule

// File: rtl/cis_phase_gen.sv
module cis_phase_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [DIV_W-1:0] per,
   input  logic [DIV_W-1:0] high,
   input  logic [DIV_W-1:0] smp,
   output logic             tick_end,
   output logic             hi_phase,
   output logic             smp_hit,
   output logic             sp_win
);

   logic [DIV_W-1:0] ph;

   always_comb begin
      tick_end = (ph == per - DIV_W'(1));
      hi_phase = (ph < high);
      smp_hit  = (ph == smp);
      // Strictly between two rising edges, wide enough to span the fall.
      sp_win   = (ph != '0) && (ph <= per - DIV_W'(2));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ph <= '0;
      else if (!run || load || tick_end)   ph <= '0;
      else                                 ph <= ph + DIV_W'(1);
   end

endmodule

// File: rtl/cis_line_seq.sv
module cis_line_seq #(
   parameter int LINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick_end,
   input  logic [LINE_W-1:0] span,
   input  logic [LINE_W-1:0] npix,
   output logic              run,
   output logic              load,
   output logic              scan_act,
   output logic              first_slot,
   output logic [LINE_W-1:0] slot
);

   logic last_slot;
   logic wrap;

   always_comb begin
      last_slot  = (slot == span - LINE_W'(1));
      wrap       = run && tick_end && last_slot;
      load       = enable && (!run || wrap);
      scan_act   = run && (slot < npix);
      first_slot = (slot == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         slot <= '0;
      end else begin
         if (run) run <= !(wrap && !enable);
         else     run <= enable;

         if (!run || wrap)  slot <= '0;
         else if (tick_end) slot <= slot + LINE_W'(1);
      end
   end

endmodule

// File: rtl/cis_line_timer.sv
module cis_line_timer #(
   parameter int DIV_W        = 8,
   parameter int DLY_W        = 8,
   parameter int LINE_W       = 16,
   parameter int DIE_W        = 5,
   parameter int PIX_PER_DIE  = 192,
   parameter int MIN_DIV      = 4,
   parameter int FAST_DIV_MAX = 20,
   parameter bit REG_OUT      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [1:0]        cfg_duty,
   input  logic [LINE_W-1:0] cfg_line,
   input  logic [DIE_W-1:0]  cfg_dies,
   input  logic [DLY_W-1:0]  cfg_dly,
   output logic              pix_clk,
   output logic              vid_rst,
   output logic              start_pulse,
   output logic              adc_stb,
   output logic              pix_valid,
   output logic [LINE_W-1:0] pix_idx,
   output logic              line_valid,
   output logic              cfg_err
);

   localparam longint MAX_DIES  = (longint'(1) << DIE_W) - 1;
   localparam longint MAX_PIX   = MAX_DIES * PIX_PER_DIE;
   localparam longint LINE_LIM  = longint'(1) << LINE_W;
   localparam longint DIV_LIM   = longint'(1) << DIV_W;

   // Elaboration-time parameter checks
   if (MIN_DIV < 4) begin : g_bad_min_div
      $error("MIN_DIV must be at least 4");
   end
   if (MIN_DIV >= DIV_LIM || FAST_DIV_MAX >= DIV_LIM) begin : g_bad_div_w
      $error("divider limits do not fit DIV_W");
   end
   if (DLY_W > DIV_W) begin : g_bad_dly_w
      $error("DLY_W must not exceed DIV_W");
   end
   if (PIX_PER_DIE < 1 || MAX_PIX >= LINE_LIM) begin : g_bad_line_w
      $error("largest chain does not fit LINE_W");
   end

   logic [DIV_W-1:0]  per, high, smp;
   logic [LINE_W-1:0] npix, span, slot;
   logic              load, run, scan_act, first_slot;
   logic              tick_end, hi_phase, smp_hit, sp_win;
   logic              err;

   cis_cfg_shadow #(
      .DIV_W(DIV_W), .DLY_W(DLY_W), .LINE_W(LINE_W), .DIE_W(DIE_W),
      .PIX_PER_DIE(PIX_PER_DIE), .MIN_DIV(MIN_DIV), .FAST_DIV_MAX(FAST_DIV_MAX)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(load),
      .div_in(cfg_div), .duty_in(cfg_duty), .line_in(cfg_line),
      .dies_in(cfg_dies), .dly_in(cfg_dly),
      .per_q(per), .high_q(high), .smp_q(smp),
      .npix_q(npix), .span_q(span), .err_q(err)
   );

   cis_phase_gen #(.DIV_W(DIV_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .load(load),
      .per(per), .high(high), .smp(smp),
      .tick_end(tick_end), .hi_phase(hi_phase), .smp_hit(smp_hit), .sp_win(sp_win)
   );

   cis_line_seq #(.LINE_W(LINE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick_end(tick_end),
      .span(span), .npix(npix),
      .run(run), .load(load), .scan_act(scan_act), .first_slot(first_slot), .slot(slot)
   );

   // Output decode from the counter state
   logic              d_clk, d_sp, d_stb, d_pv, d_lv;
   logic [LINE_W-1:0] d_idx;

   always_comb begin
      d_clk = run && hi_phase;
      d_sp  = run && first_slot && sp_win;
      d_stb = run && smp_hit;
      d_pv  = d_stb && scan_act;
      d_lv  = scan_act;
      d_idx = d_pv ? slot : '0;
   end

   assign cfg_err = err;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pix_clk     <= 1'b0;
            vid_rst     <= 1'b0;
            start_pulse <= 1'b0;
            adc_stb     <= 1'b0;
            pix_valid   <= 1'b0;
            pix_idx     <= '0;
            line_valid  <= 1'b0;
         end else begin
            pix_clk     <= d_clk;
            vid_rst     <= d_clk;
            start_pulse <= d_sp;
            adc_stb     <= d_stb;
            pix_valid   <= d_pv;
            pix_idx     <= d_idx;
            line_valid  <= d_lv;
         end
      end
   end else begin : g_comb_out
      always_comb begin
         pix_clk     = d_clk;
         vid_rst     = d_clk;
         start_pulse = d_sp;
         adc_stb     = d_stb;
         pix_valid   = d_pv;
         pix_idx     = d_idx;
         line_valid  = d_lv;
      end
   end

endmodule

// File: rtl/cis_line_timer_chk.sv
module cis_line_timer_chk #(
   parameter int LINE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_clk,
   input logic              start_pulse,
   input logic              adc_stb,
   input logic              pix_valid,
   input logic [LINE_W-1:0] pix_idx,
   input logic              line_valid,
   input logic              cfg_err
);

   logic [LINE_W-1:0] prev_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prev_idx <= '0;
      else if (pix_valid) prev_idx <= pix_idx;
   end

   AST_STB_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_stb |-> !pix_clk); // R5

   AST_SP_CLEAR_OF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_pulse) || $fell(start_pulse)) |-> !$rose(pix_clk)); // R6

   AST_SP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> line_valid); // R6

   AST_VALID_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (line_valid && adc_stb)); // R7

   AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_idx != '0) |-> (pix_idx == LINE_W'(prev_idx + LINE_W'(1)))); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R9

endmodule

bind cis_line_timer cis_line_timer_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/tb_cis_line_timer.sv
module tb_cis_line_timer;

   localparam int CLK_PERIOD  = 10;
   localparam int DIV_W       = 8;
   localparam int DLY_W       = 8;
   localparam int LINE_W      = 16;
   localparam int DIE_W       = 5;
   localparam int PIX_PER_DIE = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              enable;
   logic [DIV_W-1:0]  cfg_div;
   logic [1:0]        cfg_duty;
   logic [LINE_W-1:0] cfg_line;
   logic [DIE_W-1:0]  cfg_dies;
   logic [DLY_W-1:0]  cfg_dly;
   logic              pix_clk, vid_rst, start_pulse, adc_stb, pix_valid, line_valid, cfg_err;
   logic [LINE_W-1:0] pix_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   cis_line_timer #(
      .DIV_W(DIV_W), .DLY_W(DLY_W), .LINE_W(LINE_W), .DIE_W(DIE_W),
      .PIX_PER_DIE(PIX_PER_DIE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_div(cfg_div), .cfg_duty(cfg_duty), .cfg_line(cfg_line),
      .cfg_dies(cfg_dies), .cfg_dly(cfg_dly),
      .pix_clk(pix_clk), .vid_rst(vid_rst), .start_pulse(start_pulse),
      .adc_stb(adc_stb), .pix_valid(pix_valid), .pix_idx(pix_idx),
      .line_valid(line_valid), .cfg_err(cfg_err)
   );

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   task automatic check_eq(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Measurements of one line, start pulse rise to start pulse rise
   int m_line, m_period, m_high, m_soff, m_spw, m_falls;
   int m_nstb, m_first, m_last, m_order_bad, m_lv, m_rsw_bad;

   task automatic wait_sp_rise();
      logic prev;
      @(negedge clk);
      prev = start_pulse;
      forever begin
         @(negedge clk);
         if (start_pulse && !prev) break;
         prev = start_pulse;
      end
   endtask

   task automatic measure_line();
      int   rises;
      int   t_rise1;
      logic pc_prev, sp_prev;
      wait_sp_rise();
      m_line = -1; m_period = -1; m_high = 0; m_soff = -1; m_spw = 0; m_falls = 0;
      m_nstb = 0; m_first = -1; m_last = -1; m_order_bad = 0; m_lv = 0; m_rsw_bad = 0;
      rises = 0; t_rise1 = 0;
      pc_prev = pix_clk;
      sp_prev = 1'b1;
      for (int c = 0; c < 20000; c++) begin
         if (c > 0 && start_pulse && !sp_prev) begin
            m_line = c;
            break;
         end
         if (vid_rst != pix_clk) m_rsw_bad++;
         if (line_valid) m_lv++;
         if (start_pulse) m_spw++;
         if (start_pulse && pc_prev && !pix_clk) m_falls++;
         if (pix_clk && !pc_prev) begin
            rises++;
            if (rises == 1) t_rise1 = c;
            else if (rises == 2) m_period = c - t_rise1;
         end
         if (rises == 1 && pix_clk) m_high++;
         if (rises == 1 && adc_stb && m_soff < 0) m_soff = c - t_rise1;
         if (pix_valid) begin
            if (m_nstb == 0) m_first = int'(pix_idx);
            else if (int'(pix_idx) != m_last + 1) m_order_bad++;
            m_last = int'(pix_idx);
            m_nstb++;
         end
         pc_prev = pix_clk;
         sp_prev = start_pulse;
         @(negedge clk);
      end
   endtask

   task automatic apply_cfg(input int div, input int duty, input int dly,
                            input int dies, input int line);
      @(negedge clk);
      cfg_div  = DIV_W'(div);
      cfg_duty = 2'(duty);
      cfg_dly  = DLY_W'(dly);
      cfg_dies = DIE_W'(dies);
      cfg_line = LINE_W'(line);
      enable   = 1'b1;
      wait_sp_rise();     // the line after this one uses the new settings (R10)
      measure_line();
   endtask

   task automatic check_line(input string name, input int p, input int h, input int s,
                             input int n, input int span);
      check_eq({name, " R2 pixel period"}, m_period, p);
      check_eq({name, " R3 high width"}, m_high, h);
      check_eq({name, " R4 reset switch mismatches"}, m_rsw_bad, 0);
      check_eq({name, " R5 strobe offset"}, m_soff, s);
      check_eq({name, " R6 start width"}, m_spw, p - 2);
      check_eq({name, " R6 falls under start"}, m_falls, 1);
      check_eq({name, " R7 pixel count"}, m_nstb, n);
      check_eq({name, " R7 first index"}, m_first, 0);
      check_eq({name, " R7 last index"}, m_last, n - 1);
      check_eq({name, " R7 order errors"}, m_order_bad, 0);
      check_eq({name, " R7 line valid cycles"}, m_lv, n * p);
      check_eq({name, " R8 line cycles"}, m_line, span * p);
   endtask

   task automatic test_reset();
      int busy;
      busy = 0;
      rst_n = 1'b0; enable = 1'b0;
      cfg_div = 8'd8; cfg_duty = 2'd0; cfg_dly = '0; cfg_dies = 5'd1; cfg_line = 16'd10;
      repeat (5) @(negedge clk);
      busy += int'(pix_clk) + int'(start_pulse) + int'(adc_stb) + int'(line_valid);
      check_eq("R1 outputs in reset", busy, 0);
      check_eq("R1 err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      busy = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         busy += int'(pix_clk) + int'(vid_rst) + int'(start_pulse) + int'(adc_stb)
               + int'(pix_valid) + int'(line_valid) + int'(pix_idx != '0);
      end
      check_eq("R1 outputs while disabled", busy, 0);
   endtask

   task automatic test_half_fast();
      apply_cfg(8, 0, 1, 1, 10);
      check_line("half_fast", 8, 4, 5, 6, 10);
   endtask

   task automatic test_quarter_forced();
      apply_cfg(16, 1, 2, 1, 8);
      check_line("quarter_forced", 16, 4, 14, 6, 8);
   endtask

   task automatic test_auto_slow_two_dies();
      apply_cfg(24, 0, 0, 2, 12);
      check_line("auto_slow", 24, 6, 18, 12, 12);
   endtask

   task automatic test_half_forced_slow();
      apply_cfg(24, 2, 3, 1, 7);
      check_line("half_forced", 24, 12, 15, 6, 7);
   endtask

   task automatic test_delay_clamp();
      apply_cfg(8, 3, 200, 1, 6);
      check_line("delay_clamp R5", 8, 4, 7, 6, 6);
   endtask

   task automatic test_div_clamp_zero_dies();
      apply_cfg(1, 0, 0, 0, 6);
      check_line("div_clamp R2", 4, 2, 2, 6, 6);
   endtask

   task automatic test_line_clamp();
      check_eq("R9 err clear before short line", int'(cfg_err), 0);
      apply_cfg(8, 0, 1, 1, 3);
      check_line("line_clamp R8", 8, 4, 5, 6, 6);
      check_eq("R9 err set by short line", int'(cfg_err), 1);
      apply_cfg(8, 0, 1, 1, 10);
      check_eq("R9 err sticky", int'(cfg_err), 1);
      check_eq("R9 normal line after clamp", m_line, 80);
   endtask

   task automatic test_stop();
      int   pix;
      int   sp_rises;
      int   tail;
      logic sp_prev;
      pix = 0; sp_rises = 0; tail = 0;
      wait_sp_rise();
      sp_prev = 1'b1;
      enable = 1'b0;
      for (int c = 0; c < 160; c++) begin
         if (pix_valid) pix++;
         if (start_pulse && !sp_prev) sp_rises++;
         if (c >= 120) tail += int'(pix_clk) + int'(adc_stb) + int'(line_valid) + int'(vid_rst);
         sp_prev = start_pulse;
         @(negedge clk);
      end
      check_eq("R10 last line completes", pix, 6);
      check_eq("R10 no new line after disable", sp_rises, 0);
      check_eq("R10 outputs quiet after stop", tail, 0);
   endtask

   initial begin
      test_reset();
      test_half_fast();
      test_quarter_forced();
      test_auto_slow_two_dies();
      test_half_forced_slow();
      test_delay_clamp();
      test_div_clamp_zero_dies();
      test_line_clamp();
      test_stop();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R10 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule